// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Driver Logic

This block is the digital gate sequencer of one synchronous step-down power stage. A registered PWM command picks which of the two switches should conduct: the high-side switch while the command is high, and the low-side (synchronous rectifier) switch while it is low. The low-side switch conducts in the off phase, so the stage can rectify and can also sink current. Each gate has a comparator outside the block that reports, as a synchronous logic level, whether that gate has fallen below its turn-off threshold. The sequencer always breaks before it makes. It first drops the gate that is conducting. It then waits until the sensed feedback shows that gate is truly off, and only then raises the opposite gate.

The dead time is adaptive. It follows the discharge speed of the real gate and not a fixed count. After the off level is first seen, a short qualification window (`MIN_DLY` consecutive samples) adds margin for gates that discharge slowly. A watchdog (`TIMEOUT` cycles) keeps a lost feedback signal from stalling the stage. When it expires, it forces the pending transition and latches a fault flag that only reset clears. A command held steady gives 0 % or 100 % duty with no periodic interruption. While the block is disabled or in reset, both gates are driven low.

Top module: `gate_nonoverlap_ctl`

## Requirements
- R1: While `rst` is high, `hs_gate`, `ls_gate` and `fault` are 0 at every sample after the first clock edge, and `fault` reads 0 after reset.
- R2: When `en` is sampled low at a clock edge, both gate outputs are 0 after that edge and stay 0 while `en` remains low.
- R3: `hs_gate` and `ls_gate` are never both 1.
- R4: `ls_gate` rises only while `hs_gate` is already 0. It rises at the edge where `hs_off_sense` has been sampled 1 at `MIN_DLY` consecutive edges, or earlier only through R6. With the command changing to 0 before edge E0, `hs_gate` falls at edge E1.
- R5: `hs_gate` rises only while `ls_gate` is already 0. It rises at the edge where `ls_off_sense` has been sampled 1 at `MIN_DLY` consecutive edges, or through R6. With the command changing to 1 before edge E0, `ls_gate` falls at edge E1.
- R6: If the qualification of R4/R5 has not completed by the `TIMEOUT`-th edge after the edge that dropped the conducting gate, the opposite gate rises at that edge anyway and `fault` becomes 1 at the same edge.
- R7: Once 1, `fault` stays 1 through later switching and through `en` low, until `rst`.
- R8: A command held at 1 keeps `hs_gate` at 1 and `ls_gate` at 0 for as long as it is held (100 % duty), with no watchdog action. A command held at 0 keeps `ls_gate` at 1 (0 % duty).
- R9: `pwm_in` passes through one register. A command pulse shorter than the break-before-make sequence never raises the gate it asked for: the sequence falls back, and the previously conducting gate rises again only through its own qualification.
- R10: On leaving the disabled state with `en` at 1, the gate chosen by the registered command rises only after the opposite gate's off-sense qualifies, as in R4/R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | 1 = switching allowed, 0 = both gates held low |
| pwm_in | input | 1 | Command: 1 = high-side conducts, 0 = low-side conducts |
| hs_off_sense | input | 1 | 1 = high-side gate measured below its off threshold |
| ls_off_sense | input | 1 | 1 = low-side gate measured below its off threshold |
| hs_gate | output | 1 | High-side gate command (registered) |
| ls_gate | output | 1 | Low-side gate command (registered) |
| fault | output | 1 | Sticky flag: a watchdog forced a transition |

## Verification
A sequencer stuck in the wrong wait state, or a qualification counter left with a stale count, shows up at the ports as a gate that rises one or more edges earlier or later than the latency formula of R4/R5 predicts. The bench therefore measures the rise cycle to the exact edge for several feedback latencies. A missing break step appears in the same cycle as overlapping gate commands. A watchdog that counts from the wrong origin moves the forced edge and the `fault` rise away from edge `TIMEOUT` after the drop. A lost sticky bit appears at the first normal transition after the timeout.

// File: rtl/gnd_pkg.sv
package gnd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HS_ON   = 3'd1,
    ST_LS_ON   = 3'd2,
    ST_WAIT_HS = 3'd3,   // high side requested, waiting for low side off
    ST_WAIT_LS = 3'd4    // low side requested, waiting for high side off
  } drv_state_e;

  localparam int unsigned SIDE_HS = 0;  // qualifier watching the high-side sense
  localparam int unsigned SIDE_LS = 1;  // qualifier watching the low-side sense
  localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/gnd_cmd_reg.sv
module gnd_cmd_reg #(
  parameter int unsigned STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/gnd_off_qual.sv
module gnd_off_qual #(
  parameter int unsigned MIN_DLY = 2,
  parameter int unsigned TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,        // sequencer is waiting on this gate
  input  logic off_sense,  // gate measured off
  output logic go,         // off level qualified
  output logic expired     // watchdog ran out before qualification
);
  localparam int unsigned DW = (MIN_DLY < 2) ? 1 : $clog2(MIN_DLY + 1);
  localparam int unsigned WW = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT + 1);
  localparam logic [DW-1:0] DWELL_LAST = DW'(MIN_DLY - 1);
  localparam logic [WW-1:0] WAIT_LAST  = WW'(TIMEOUT - 1);

  logic [DW-1:0] dwell;
  logic [WW-1:0] wcnt;

  assign go      = arm && off_sense && (dwell == DWELL_LAST);
  assign expired = arm && !go && (wcnt == WAIT_LAST);

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      dwell <= '0;
      wcnt  <= '0;
    end else begin
      if (wcnt != WAIT_LAST) wcnt <= wcnt + 1'b1;
      if (!off_sense)                dwell <= '0;
      else if (dwell != DWELL_LAST)  dwell <= dwell + 1'b1;
    end
  end

  generate
    if (MIN_DLY > 1) begin : g_chk
      // R4
      qual_needs_history_chk: assert property (@(posedge clk) disable iff (rst)
        go |-> $past(off_sense));
    end
    if (TIMEOUT > 1) begin : g_wchk
      // R6
      no_instant_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        (arm && !$past(arm)) |-> !expired);
    end
  endgenerate
endmodule

// File: rtl/gnd_fsm.sv
module gnd_fsm
  import gnd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pwm_q,
  input  logic hs_off_sense,
  input  logic ls_off_sense,
  input  logic hs_go,
  input  logic hs_exp,
  input  logic ls_go,
  input  logic ls_exp,
  output logic arm_hs,     // waiting on the high-side off level
  output logic arm_ls,     // waiting on the low-side off level
  output logic hs_gate,
  output logic ls_gate,
  output logic fault
);
  drv_state_e state, nxt;
  logic       force_set;

  always_comb begin
    nxt       = state;
    force_set = 1'b0;
    if (!en) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:    nxt = pwm_q ? ST_WAIT_HS : ST_WAIT_LS;
        ST_HS_ON:   if (!pwm_q) nxt = ST_WAIT_LS;
        ST_LS_ON:   if (pwm_q)  nxt = ST_WAIT_HS;
        ST_WAIT_HS: begin
          if (!pwm_q) nxt = ST_WAIT_LS;
          else if (ls_go || ls_exp) begin
            nxt       = ST_HS_ON;
            force_set = ls_exp;
          end
        end
        ST_WAIT_LS: begin
          if (pwm_q) nxt = ST_WAIT_HS;
          else if (hs_go || hs_exp) begin
            nxt       = ST_LS_ON;
            force_set = hs_exp;
          end
        end
        default:    nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      hs_gate <= 1'b0;
      ls_gate <= 1'b0;
      fault   <= 1'b0;
    end else begin
      state   <= nxt;
      hs_gate <= (nxt == ST_HS_ON);
      ls_gate <= (nxt == ST_LS_ON);
      fault   <= fault | force_set;
    end
  end

  assign arm_hs = (state == ST_WAIT_LS);
  assign arm_ls = (state == ST_WAIT_HS);

  // R2
  disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!hs_gate && !ls_gate));
  // R4
  ls_after_hs_off_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_gate) |-> ($past(!hs_gate) && ($past(hs_off_sense) || fault)));
  // R5
  hs_after_ls_off_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_gate) |-> ($past(!ls_gate) && ($past(ls_off_sense) || fault)));
  // R7
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);
  // R6
  fault_with_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> ($rose(hs_gate) || $rose(ls_gate)));
  // R8
  full_duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && pwm_q && hs_gate) |=> hs_gate);
endmodule

// File: rtl/gate_nonoverlap_ctl.sv
module gate_nonoverlap_ctl
  import gnd_pkg::*;
#(
  parameter int unsigned MIN_DLY    = 2,
  parameter int unsigned TIMEOUT    = 64,
  parameter int unsigned CMD_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pwm_in,
  input  logic hs_off_sense,
  input  logic ls_off_sense,
  output logic hs_gate,
  output logic ls_gate,
  output logic fault
);
  logic                 pwm_q;
  logic [NUM_SIDES-1:0] sense, arm, go, expd;

  gnd_cmd_reg #(.STAGES(CMD_STAGES)) u_cmd (
    .clk(clk), .rst(rst), .d(pwm_in), .q(pwm_q)
  );

  assign sense[SIDE_HS] = hs_off_sense;
  assign sense[SIDE_LS] = ls_off_sense;

  for (genvar i = 0; i < NUM_SIDES; i++) begin : g_qual
    gnd_off_qual #(.MIN_DLY(MIN_DLY), .TIMEOUT(TIMEOUT)) u_q (
      .clk(clk), .rst(rst), .arm(arm[i]), .off_sense(sense[i]),
      .go(go[i]), .expired(expd[i])
    );
  end

  gnd_fsm u_fsm (
    .clk(clk), .rst(rst), .en(en), .pwm_q(pwm_q),
    .hs_off_sense(hs_off_sense), .ls_off_sense(ls_off_sense),
    .hs_go(go[SIDE_HS]), .hs_exp(expd[SIDE_HS]),
    .ls_go(go[SIDE_LS]), .ls_exp(expd[SIDE_LS]),
    .arm_hs(arm[SIDE_HS]), .arm_ls(arm[SIDE_LS]),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .fault(fault)
  );
endmodule

// File: tb/tb_gate_nonoverlap_ctl.sv
module tb_gate_nonoverlap_ctl;
  localparam int MIN_DLY = 2;
  localparam int TIMEOUT = 64;
  localparam int NV      = 7;
  // {target command, feedback latency of the gate being switched off}
  localparam logic [8:0] VEC [NV] = '{
    {1'b1, 8'd1}, {1'b0, 8'd1}, {1'b1, 8'd3}, {1'b0, 8'd6},
    {1'b1, 8'd2}, {1'b0, 8'd9}, {1'b1, 8'd200}
  };

  logic clk = 1'b0, rst = 1'b1, en = 1'b1, pwm_in = 1'b0;
  logic hs_off_sense, ls_off_sense, hs_gate, ls_gate, fault;
  int   checks = 0, fails = 0, overlaps = 0;
  int   hs_lat = 1, ls_lat = 1, hcnt = 0, lcnt = 0;

  always #10 clk = ~clk;

  gate_nonoverlap_ctl #(.MIN_DLY(MIN_DLY), .TIMEOUT(TIMEOUT)) dut (
    .clk(clk), .rst(rst), .en(en), .pwm_in(pwm_in),
    .hs_off_sense(hs_off_sense), .ls_off_sense(ls_off_sense),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .fault(fault)
  );

  assign hs_off_sense = (hcnt >= hs_lat);
  assign ls_off_sense = (lcnt >= ls_lat);

  // gate discharge model and overlap monitor (R3)
  initial forever begin
    @(negedge clk);
    if (hs_gate === 1'b1) hcnt = 0; else if (hcnt < 255) hcnt = hcnt + 1;
    if (ls_gate === 1'b1) lcnt = 0; else if (lcnt < 255) lcnt = lcnt + 1;
    if (hs_gate === 1'b1 && ls_gate === 1'b1) overlaps = overlaps + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    wait_neg(3);
    chk(hs_gate === 1'b0 && ls_gate === 1'b0, "R1 gates in reset", {hs_gate, ls_gate}, 0);
    chk(fault === 1'b0, "R1 fault in reset", fault, 0);
    rst = 1'b0;

    // R8 0% duty: command low keeps low side on
    wait_neg(30);
    chk(ls_gate === 1'b1 && hs_gate === 1'b0, "R8 zero duty", {hs_gate, ls_gate}, 1);

    // R9 one-cycle command pulse never raises the high side
    begin
      bit hs_seen = 0, ls_dropped = 0;
      pwm_in = 1'b1; @(negedge clk); pwm_in = 1'b0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (hs_gate) hs_seen = 1;
        if (!ls_gate) ls_dropped = 1;
      end
      chk(!hs_seen, "R9 short pulse high side", hs_seen, 0);
      chk(ls_dropped && ls_gate === 1'b1, "R9 fallback to low side", ls_gate, 1);
    end

    // R8 100% duty: command held high for a long stretch
    ls_lat = 1; pwm_in = 1'b1;
    wait_neg(10);
    begin
      bit broke = 0;
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if (!hs_gate || ls_gate) broke = 1;
      end
      chk(!broke, "R8 full duty hold", broke, 0);
      chk(fault === 1'b0, "R8 no watchdog when on", fault, 0);
    end

    // R2 disable
    en = 1'b0;
    @(negedge clk);
    chk(!hs_gate && !ls_gate, "R2 gates low after disable", {hs_gate, ls_gate}, 0);
    wait_neg(10);
    chk(!hs_gate && !ls_gate, "R2 gates stay low", {hs_gate, ls_gate}, 0);

    // R10 re-enable with command high: sense already qualified
    en = 1'b1;
    begin
      int n = 0;
      for (int k = 1; k <= 20; k++) begin
        @(negedge clk);
        if (n == 0 && hs_gate) n = k;
      end
      chk(n == MIN_DLY + 1, "R10 re-enable rise cycle", n, MIN_DLY + 1);
    end
    pwm_in = 1'b0;
    wait_neg(20);

    // vector table: R4, R5, R6
    for (int i = 0; i < NV; i++) begin
      logic dir;
      int lat, exp_n, n;
      bit exp_fault, old_low;
      dir = VEC[i][8];
      lat = int'(VEC[i][7:0]);
      if (dir) ls_lat = lat; else hs_lat = lat;
      exp_n = lat + MIN_DLY + 1;
      exp_fault = 0;
      if (exp_n > TIMEOUT + 2) begin exp_n = TIMEOUT + 2; exp_fault = 1; end
      n = 0; old_low = 0;
      pwm_in = dir;
      for (int k = 1; k <= 100; k++) begin
        @(negedge clk);
        if (k == 2) old_low = dir ? !ls_gate : !hs_gate;
        if (n == 0 && (dir ? hs_gate : ls_gate)) n = k;
      end
      if (dir) begin
        chk(old_low, "R5 low side dropped first", !old_low, 0);
        chk(n == exp_n, exp_fault ? "R6 forced high side edge" : "R5 high side rise cycle", n, exp_n);
      end else begin
        chk(old_low, "R4 high side dropped first", !old_low, 0);
        chk(n == exp_n, "R4 low side rise cycle", n, exp_n);
      end
      chk(fault === exp_fault, "R6 fault state", fault, exp_fault);
    end

    // R7 fault survives switching and disable
    hs_lat = 1; pwm_in = 1'b0;
    wait_neg(20);
    chk(fault === 1'b1 && ls_gate === 1'b1, "R7 sticky after switching", fault, 1);
    en = 1'b0; wait_neg(5); en = 1'b1;
    chk(fault === 1'b1, "R7 sticky through disable", fault, 1);

    // R1 reset clears fault and holds gates low
    rst = 1'b1; pwm_in = 1'b1;
    wait_neg(2);
    chk(fault === 1'b0, "R1 fault cleared", fault, 0);
    chk(!hs_gate && !ls_gate, "R1 gates low in reset", {hs_gate, ls_gate}, 0);
    wait_neg(10);
    chk(!hs_gate && !ls_gate, "R1 gates stay low in reset", {hs_gate, ls_gate}, 0);
    rst = 1'b0;
    wait_neg(10);

    // R3 no overlap at any sample
    chk(overlaps == 0, "R3 overlap samples", overlaps, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule